// File: doc/BRIEF.md
# Lockout Sequence Recognizer

This block watches a single serial bit stream, one bit per rising clock edge. It raises its flag output while the three most recent bits received since reset read 0, then 1, then 0 in time order. Matches may overlap, so a stream such as 0-1-0-1-0 raises the flag twice.

A second pattern disables the block for good. That pattern is 1 followed by two 0s. Once it has occurred, the block drops into a terminal state that ignores all further input. The flag then stays low until the next synchronous reset.

The flag is a Moore output: it is decoded from the state register alone. It changes only on a clock edge, one cycle after the bit that completes a match is sampled. A controller places the block beside a serial stream and uses the flag as a qualifier. It uses reset to re-arm the block after a lockout.

Top module: `lockout_seq_rec`

## Requirements
- R1: While `rst` is high at a rising edge, the state returns to idle. `match_o` reads 0 after that edge.
- R2: After an edge, `match_o` is 1 exactly when both hold: the last three bits sampled since reset were 0, 1, 0 (oldest first), and the lockout pattern has not occurred.
- R3: Matches overlap. The stream 0,1,0,1,0 after reset gives `match_o` = 0,0,1,0,1 after the successive edges.
- R4: Bits sampled before a reset take no part in matching or lockout. Fewer than three bits since reset never assert `match_o`.
- R5: Once the bits 1, 0, 0 (oldest first) have been sampled in a row since reset, `match_o` stays 0 for every later input until reset.
- R6: A reset clears the lockout. Matching then resumes with a fresh history.
- R7: Long runs of 0s, or long runs of 1s, before a 0-1-0 neither block nor fake a match. Only the last three bits and the lockout history count.
- R8: `match_o` depends on the state only. Changing `bit_i` between edges leaves `match_o` unchanged until the next rising edge.
- R9: Reference streams give the expected results after reset. Input 00101010010 gives output 00010101000, and input 11011010010 gives output 00000001000 (bit by bit, first bit leftmost).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_i | input | 1 | Serial input bit, sampled on each rising edge |
| match_o | output | 1 | High while the last three bits are 0-1-0 and no lockout has occurred |

## Verification
Uniform random bits reach the lockout pattern within a handful of cycles. After that the flag is stuck low, so long stretches of overlapping matches are hard to reach from the ports.

To reach them, the random stimulus is biased. Whenever the last two bits sent were 1 then 0, the next bit is almost always a 1. This keeps the block in its live states for hundreds of cycles.

Sparse random resets are added to re-arm the block, so the lockout transition itself is still exercised many times. Directed streams cover the reference vectors, the effect of history before a reset, and input changes between edges.

// File: rtl/lockout_seq_pkg.sv
package lockout_seq_pkg;

   // Recognizer states: names show the relevant suffix of the stream
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_Z    = 3'd1,   // ...0, no 1 seen yet
      ST_ZO   = 3'd2,   // ...01
      ST_ZOZ  = 3'd3,   // ...010, flag state
      ST_O    = 3'd4,   // ...1, not part of 01
      ST_OZ   = 3'd5,   // ...10
      ST_DEAD = 3'd6    // lockout pattern seen
   } rec_state_e;

   localparam int unsigned STATE_W = $bits(rec_state_e);

endpackage

// File: rtl/lockout_seq_next.sv
module lockout_seq_next
   import lockout_seq_pkg::*;
(
   input  rec_state_e cur_i,
   input  logic       bit_i,
   output rec_state_e nxt_o
);

   always_comb begin
      nxt_o = cur_i;
      unique case (cur_i)
         ST_IDLE: nxt_o = bit_i ? ST_O  : ST_Z;
         ST_Z:    nxt_o = bit_i ? ST_ZO : ST_Z;
         ST_ZO:   nxt_o = bit_i ? ST_O  : ST_ZOZ;
         ST_ZOZ:  nxt_o = bit_i ? ST_ZO : ST_DEAD;
         ST_O:    nxt_o = bit_i ? ST_O  : ST_OZ;
         ST_OZ:   nxt_o = bit_i ? ST_ZO : ST_DEAD;
         ST_DEAD: nxt_o = ST_DEAD;
         default: nxt_o = ST_IDLE;
      endcase
   end

endmodule

// File: rtl/lockout_seq_state.sv
module lockout_seq_state
   import lockout_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  rec_state_e nxt_i,
   output rec_state_e cur_o
);

   always_ff @(posedge clk) begin
      if (rst) cur_o <= ST_IDLE;
      else     cur_o <= nxt_i;
   end

endmodule

// File: rtl/lockout_seq_out.sv
module lockout_seq_out
   import lockout_seq_pkg::*;
(
   input  rec_state_e cur_i,
   output logic       flag_o
);

   always_comb flag_o = (cur_i == ST_ZOZ);

endmodule

// File: rtl/lockout_seq_rec.sv
module lockout_seq_rec
   import lockout_seq_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic bit_i,
   output logic match_o
);

   initial begin
      if (STATE_W < 3) $error("state register too narrow for seven states");
   end

   rec_state_e cur_st;
   rec_state_e nxt_st;

   lockout_seq_next i_next (
      .cur_i (cur_st),
      .bit_i (bit_i),
      .nxt_o (nxt_st)
   );

   lockout_seq_state i_state (
      .clk   (clk),
      .rst   (rst),
      .nxt_i (nxt_st),
      .cur_o (cur_st)
   );

   lockout_seq_out i_out (
      .cur_i  (cur_st),
      .flag_o (match_o)
   );

endmodule

// File: rtl/lockout_seq_chk.sv
module lockout_seq_chk (
   input logic clk,
   input logic rst,
   input logic bit_i,
   input logic match_o
);

   // Independent history of sampled bits, kept from the ports only
   logic [2:0] hist;
   logic [1:0] cnt;
   logic       locked;

   always_ff @(posedge clk) begin
      if (rst) begin
         hist   <= 3'b000;
         cnt    <= 2'd0;
         locked <= 1'b0;
      end else begin
         hist <= {hist[1:0], bit_i};
         if (cnt != 2'd3) cnt <= cnt + 2'd1;
         if (cnt >= 2'd2 && {hist[1:0], bit_i} == 3'b100) locked <= 1'b1;
      end
   end

   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !match_o); // R1

   AST_FLAG_NEEDS_PATTERN: assert property (@(posedge clk) disable iff (rst)
      match_o |-> (cnt == 2'd3 && hist == 3'b010)); // R2

   AST_PATTERN_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
      (!locked && cnt == 2'd3 && hist == 3'b010) |-> match_o); // R3

   AST_LOCKOUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
      locked |-> !match_o); // R5

   AST_SHORT_HISTORY: assert property (@(posedge clk) disable iff (rst)
      (cnt != 2'd3) |-> !match_o); // R4

endmodule

bind lockout_seq_rec lockout_seq_chk i_chk (
   .clk     (clk),
   .rst     (rst),
   .bit_i   (bit_i),
   .match_o (match_o)
);

// File: tb/test_lockout_seq_rec.sv
module test_lockout_seq_rec;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_i = 1'b0;
   logic match_o;

   int n_cmp = 0;
   int n_bad = 0;

   // reference model state
   logic [2:0] m_hist = 3'b000;
   int         m_cnt  = 0;
   logic       m_lock = 1'b0;

   always #4 clk = ~clk;

   lockout_seq_rec i_lockout_seq_rec (
      .clk     (clk),
      .rst     (rst),
      .bit_i   (bit_i),
      .match_o (match_o)
   );

   function automatic logic exp_flag(input logic [2:0] h, input int c, input logic lk);
      return (c >= 3) && !lk && (h == 3'b010);
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: match_o=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #2;
      rst = 1'b0;
      m_hist = 3'b000; m_cnt = 0; m_lock = 1'b0;
      check("R1", match_o, 1'b0);
   endtask

   task automatic step(input logic b, input string req);
      @(negedge clk);
      bit_i = b;
      @(posedge clk);
      #2;
      m_hist = {m_hist[1:0], b};
      m_cnt++;
      if (m_cnt >= 3 && m_hist == 3'b100) m_lock = 1'b1;
      check(req, match_o, exp_flag(m_hist, m_cnt, m_lock));
   endtask

   task automatic run_vec(input string s_in, input string s_out, input string req);
      do_reset();
      for (int i = 0; i < s_in.len(); i++) begin
         step(s_in[i] == "1", req);
         check(req, match_o, s_out[i] == "1");
      end
   endtask

   initial begin
      #1_600_000;
      n_bad++;
      $display("FAIL watchdog: timeout actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic b;
      @(posedge clk);
      #2;
      check("R1", match_o, 1'b0);

      // R9 reference streams
      run_vec("00101010010", "00010101000", "R9");
      run_vec("11011010010", "00000001000", "R9");

      // R3 overlap
      run_vec("01010", "00101", "R3");

      // R7 long runs
      do_reset();
      for (int i = 0; i < 20; i++) step(1'b0, "R7");
      step(1'b1, "R7"); step(1'b0, "R7");
      check("R7", match_o, 1'b1);
      do_reset();
      for (int i = 0; i < 20; i++) step(1'b1, "R7");
      step(1'b0, "R7"); step(1'b1, "R7"); step(1'b0, "R7");
      check("R7", match_o, 1'b1);

      // R4 history before reset ignored
      do_reset();
      step(1'b0, "R4"); step(1'b1, "R4");
      do_reset();
      step(1'b0, "R4");
      check("R4", match_o, 1'b0);
      do_reset();
      step(1'b1, "R4"); step(1'b0, "R4");
      do_reset();
      step(1'b0, "R4"); step(1'b1, "R4"); step(1'b0, "R4");
      check("R4", match_o, 1'b1);

      // R5 lockout then R6 release
      do_reset();
      step(1'b1, "R5"); step(1'b0, "R5"); step(1'b0, "R5");
      step(1'b1, "R5"); step(1'b0, "R5");
      check("R5", match_o, 1'b0);
      step(1'b1, "R5"); step(1'b0, "R5");
      check("R5", match_o, 1'b0);
      do_reset();
      step(1'b0, "R6"); step(1'b1, "R6"); step(1'b0, "R6");
      check("R6", match_o, 1'b1);

      // R8 input wiggle between edges
      do_reset();
      step(1'b0, "R8"); step(1'b1, "R8"); step(1'b0, "R8");
      @(negedge clk);
      bit_i = 1'b0; #1; bit_i = 1'b1; #1;
      check("R8", match_o, 1'b1);
      bit_i = 1'b0; #1;
      check("R8", match_o, 1'b1);
      @(posedge clk); #2;
      m_hist = {m_hist[1:0], 1'b0}; m_cnt++;
      if (m_hist == 3'b100) m_lock = 1'b1;
      check("R8", match_o, 1'b0);

      // biased random stream with sparse resets
      void'($urandom(32'd20240611));
      do_reset();
      for (int i = 0; i < 6000; i++) begin
         if ($urandom_range(0, 299) == 0) begin
            do_reset();
         end else begin
            if (m_cnt >= 2 && m_hist[1:0] == 2'b10)
               b = ($urandom_range(0, 15) != 0);
            else
               b = $urandom_range(0, 1) != 0;
            step(b, "R2");
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule